// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of data words by a fixed number of enabled clock cycles. It does not use a chain of flip-flops. It keeps every word in one simple dual-port memory array that is used as a ring. On each enabled edge the incoming word is written at a write pointer and the word at a read pointer is loaded into an output register. Both pointers then advance by one and wrap at the end of the array.

The read pointer always stays one slot ahead of the write pointer. As a result, the output behaves exactly like the last stage of a register chain that is `DEPTH` stages long. The chain advances only while the shift enable is high. The array has no reset and no control signal other than the clock and the enable, so it can be mapped onto on-chip block memory.

A sticky `filled` output rises once `DEPTH` words have entered since reset. Until then the output word is not defined, and a consumer must ignore it.

Top module: `ram_delay_line`

## Requirements
- R1: Three parameters set the design. `WIDTH` is the word width and defaults to 16. `DEPTH` is the number of stages, with a minimum of 2 and a default of 2678. `FALL_EDGE` selects the active edge: 1 means the falling edge, 0 means the rising edge.
- R2: Consider the enabled edge that captures word k, counting enabled edges from 0 after reset. From that edge on, `dout` equals the word captured at enabled edge k-DEPTH+1. This is the same value the last stage of a `DEPTH`-stage register chain would hold.
- R3: On an active edge where `shift_en` is low, the following stay unchanged: `dout`, `filled`, both pointers and the stored words.
- R4: Each pointer counts modulo `DEPTH`. It steps from `DEPTH`-1 back to 0 on an enabled edge.
- R5: After reset the write pointer is `DEPTH`-1 and the read pointer is 0. At all times the read pointer equals the write pointer plus one, modulo `DEPTH`.
- R6: `filled` is 0 after reset. It becomes 1 on the enabled edge that captures the `DEPTH`-th word and then stays 1 until the next reset.
- R7: The active-low asynchronous reset `rst_n` clears the two pointers and `filled`, and nothing else. After reset the line needs `DEPTH` new words before `filled` rises again.
- R8: With `FALL_EDGE`=1, the memory, the pointers, `dout` and `filled` all update on the falling edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the pointers and the flag |
| shift_en | input | 1 | Advances the line by one stage on an active edge |
| din | input | WIDTH | Word entering the line |
| dout | output | WIDTH | Word leaving the line (registered memory read) |
| filled | output | 1 | High once DEPTH words have entered since reset |

## Verification
Assertions check several rules on every active edge: the pointers and output hold while the enable is low, the pointers wrap, the read pointer stays one slot ahead of the write pointer, and `filled` stays high once set. The exact delay, the value carried through the memory across several wraps, the choice of active edge and the restart after a mid-stream reset can only be shown by the bench. It compares every output against a behavioural queue model while the enable pattern has random gaps.

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
  parameter int WIDTH     = 16,
  parameter int DEPTH     = 2678,
  parameter bit FALL_EDGE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             filled
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    seen;

  wire aclk = FALL_EDGE ? ~clk : clk;

  assign filled = (seen == FULLCNT);

  always_ff @(posedge aclk) begin
    if (shift_en) begin
      store[wr_ptr] <= din;
      dout          <= store[rd_ptr];
    end
  end

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= LAST;
      rd_ptr <= '0;
      seen   <= '0;
    end else if (shift_en) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (!filled) seen <= seen + 1'b1;
    end
  end

  // R3: a disabled edge moves nothing
  a_r3_hold: assert property (@(posedge aclk) disable iff (!rst_n)
    !shift_en |=> $stable(wr_ptr) && $stable(rd_ptr) && $stable(dout) && $stable(filled));

  // R4: modulo-DEPTH wrap of the read pointer
  a_r4_wrap: assert property (@(posedge aclk) disable iff (!rst_n)
    (shift_en && rd_ptr == LAST) |=> rd_ptr == '0);

  a_r4_range: assert property (@(posedge aclk) disable iff (!rst_n)
    (rd_ptr <= LAST) && (wr_ptr <= LAST));

  // R5: read pointer one slot ahead of the write pointer
  a_r5_distance: assert property (@(posedge aclk) disable iff (!rst_n)
    rd_ptr == ((wr_ptr == LAST) ? '0 : wr_ptr + 1'b1));

  // R6: filled is sticky
  a_r6_sticky: assert property (@(posedge aclk) disable iff (!rst_n)
    filled |=> filled);

  // R6: filled rises only on an enabled edge
  a_r6_rise: assert property (@(posedge aclk) disable iff (!rst_n)
    $rose(filled) |-> $past(shift_en));
endmodule

// File: tb/test_ram_delay_line.sv
module test_ram_delay_line;
  localparam int W = 16;
  localparam int N = 2678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic filled;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [W-1:0] q[$];
  int writes = 0;

  always #5 clk = ~clk;

  // R1: default parameters WIDTH=16, DEPTH=2678, falling edge
  ram_delay_line #(.WIDTH(W), .DEPTH(N), .FALL_EDGE(1'b1)) i_ram_delay_line (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .din(din), .dout(dout), .filled(filled)
  );

  task automatic check_state(input string tag);
    checks++;
    if (filled !== (writes >= N)) begin
      fails++;
      $display("FAIL %s filled actual=%0b expected=%0b", tag, filled, writes >= N);
    end
    if (writes >= N) begin
      checks++;
      if (dout !== q[0]) begin
        fails++;
        $display("FAIL %s dout actual=%h expected=%h", tag, dout, q[0]);
      end
    end
  endtask

  // drive at posedge+1, check after the falling edge (R8)
  task automatic step(input bit en, input string tag);
    @(posedge clk); #1;
    shift_en = en;
    din = W'($urandom);
    if (en) begin
      q.push_back(din);
      if (q.size() > N) void'(q.pop_front());
      writes++;
    end
    @(negedge clk); #1;
    check_state(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #23;
    checks++;
    if (filled !== 1'b0) begin
      fails++;
      $display("FAIL R7 reset filled actual=%0b expected=0", filled);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R6: fill with continuous enable, filled rises on the N-th word
    for (int i = 0; i < N; i++) step(1'b1, "R6");
    // R2/R4/R5: random gaps across several wraps of both pointers
    for (int i = 0; i < 9000; i++) step(($urandom % 10) < 7, "R2");
    // R3: long idle stretch, output and flag must hold
    for (int i = 0; i < 200; i++) step(1'b0, "R3");
    for (int i = 0; i < 500; i++) step(($urandom % 4) != 0, "R2");

    // R7: mid-stream reset clears the flag, line refills
    @(posedge clk); #1;
    shift_en = 1'b0;
    rst_n = 1'b0;
    q.delete();
    writes = 0;
    @(negedge clk); #1;
    checks++;
    if (filled !== 1'b0) begin
      fails++;
      $display("FAIL R7 filled after reset actual=%0b expected=0", filled);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < N + 1500; i++) step(($urandom % 5) != 0, "R7");

    // R8: alternating enable, every check lands right after the falling edge
    for (int i = 0; i < 300; i++) step(i[0], "R8");
    finish_up();
  end
endmodule